// File: doc/BRIEF.md
# Seek and Attention Status Tracker

This block keeps the positioning status of several disk drive units behind one controller. A positioning command names a unit, a target cylinder and whether it is a plain seek or a recalibrate. The block records the cylinder each unit's heads sit on. It drops the unit's attention and ready lines while the heads move. It raises them again when the drive reports arrival. If no arrival comes within a timeout window, the unit goes to a failed state: attention comes back up, ready stays low and a seek-incomplete flag is set.

A seek to the cylinder the heads already occupy starts no motion, and attention stays up. A recalibrate always moves the heads. It finishes at cylinder zero, and it is the only command that clears seek-incomplete. Several units can move at the same time. After each accepted command there is a short selection hold, and commands arriving during the hold are dropped. Two interrupt requests are produced: one for pending attention events and one for units flagged seek-incomplete. Each has its own mask input.

Top module: `seek_attn_tracker`

## Requirements
- R1: After reset every unit has attention high, ready high, seek-incomplete low, moving low and cylinder 0. `hold_busy`, `attn_irq` and `err_irq` are low.
- R2: A seek (`cmd_recal`=0) to a cylinder different from the unit's current one sets that unit's `seeking` bit and clears its `attn` and `ready` bits from the clock edge that accepts it.
- R3: A seek to the unit's current cylinder starts no motion. `attn` stays high, `ready` is high, `seeking` stays low, the cylinder is unchanged and no attention event is recorded.
- R4: An `arrive` pulse on a moving unit ends the motion. The cylinder becomes the target, `attn` and `ready` go high, and an attention event becomes pending.
- R5: A unit that has been moving for TIMEOUT_CYC clock edges with no arrival fails at that edge, and not before. `attn` goes high, `seek_inc` goes high, `ready` stays low, the cylinder is unchanged and an attention event becomes pending.
- R6: A recalibrate (`cmd_recal`=1) always starts motion, even at cylinder 0. On arrival the cylinder becomes 0, `attn` and `ready` go high and `seek_inc` clears.
- R7: An accepted command holds `hold_busy` high for HOLD_CYC cycles. Any command presented while `hold_busy` is high is ignored.
- R8: Different units may move at the same time. Each completes on its own arrival without changing the other's state.
- R9: A command addressed to a unit that is still moving is ignored. It does not start a hold and it does not change that unit's target.
- R10: `attn_irq` is high when any unit has a pending attention event and `attn_mask` is low. A pulse on `attn_ack[u]` clears unit u's pending event. `err_irq` is high when any unit has `seek_inc` set and `err_mask` is low.
- R11: An `arrive` pulse on a unit that is not moving has no effect on its cylinder or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_recal | input | 1 | 0 = seek, 1 = recalibrate |
| cmd_unit | input | UNIT_W | Addressed unit |
| cmd_cyl | input | CYL_W | Target cylinder of a seek |
| arrive | input | UNITS | Per-unit arrival pulse from the drive |
| attn_ack | input | UNITS | Per-unit clear of a pending attention event |
| attn_mask | input | 1 | Masks `attn_irq` |
| err_mask | input | 1 | Masks `err_irq` |
| attn | output | UNITS | Per-unit attention line |
| ready | output | UNITS | Per-unit ready status |
| seek_inc | output | UNITS | Per-unit seek-incomplete status |
| seeking | output | UNITS | Per-unit heads-in-motion status |
| unit_cyl | output | UNITS*CYL_W | Per-unit current cylinder, unit u at bits u*CYL_W upward |
| hold_busy | output | 1 | Selection hold active |
| attn_irq | output | 1 | Attention interrupt request |
| err_irq | output | 1 | Seek-incomplete interrupt request |

## Verification
The bench builds the block with three units, an 8-bit cylinder, a timeout of 40 cycles and a hold of 3 cycles. The short timeout brings the failure edge within reach, so the bench can check both the last cycle still in motion and the failing edge. The short hold lets it drop a command inside the hold window and then accept one on another unit right after, so two units move at the same time. Three units leave one unit idle while the other two overlap.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_DONE = 2'd2,
    ST_FAIL = 2'd3
  } unit_state_e;

  // Motion is needed for every recalibrate, and for a seek whose target
  // differs from the present cylinder.
  function automatic logic needs_motion(input logic recal,
                                        input logic [15:0] cur,
                                        input logic [15:0] tgt);
    return recal || (cur != tgt);
  endfunction

  // Cylinder a command moves the heads to.
  function automatic logic [15:0] goal_cyl(input logic recal,
                                           input logic [15:0] tgt);
    return recal ? 16'd0 : tgt;
  endfunction

endpackage

// File: rtl/sat_hold_timer.sv
module sat_hold_timer #(
  parameter int HOLD_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(HOLD_CYC);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= HOLD_INIT;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  p_hold_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sat_unit.sv
module sat_unit
  import sat_pkg::*;
#(
  parameter int CYL_W       = 8,
  parameter int TIMEOUT_CYC = 5_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_recal,
  input  logic [CYL_W-1:0] start_cyl,
  input  logic             arrive,
  input  logic             ack,
  output logic             attn,
  output logic             ready,
  output logic             seek_inc,
  output logic             moving,
  output logic             pend,
  output logic [CYL_W-1:0] cyl
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);

  unit_state_e     state;
  logic [TW-1:0]   tmo_cnt;
  logic [CYL_W-1:0] tgt;
  logic            recal_r;

  logic start_move, start_short, ev_arrive, ev_timeout;

  assign start_move  = start && needs_motion(start_recal, 16'(cyl), 16'(start_cyl));
  assign start_short = start && !start_move;
  assign moving      = (state == ST_MOVE);
  assign ev_arrive   = moving && arrive;
  assign ev_timeout  = moving && !arrive && (tmo_cnt == TMO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      tmo_cnt  <= '0;
      tgt      <= '0;
      recal_r  <= 1'b0;
      attn     <= 1'b1;
      ready    <= 1'b1;
      seek_inc <= 1'b0;
      cyl      <= '0;
    end else if (start_move) begin
      state   <= ST_MOVE;
      tmo_cnt <= '0;
      tgt     <= CYL_W'(goal_cyl(start_recal, 16'(start_cyl)));
      recal_r <= start_recal;
      attn    <= 1'b0;
      ready   <= 1'b0;
    end else if (start_short) begin
      state <= ST_DONE;
      ready <= 1'b1;
    end else if (ev_arrive) begin
      state <= ST_DONE;
      cyl   <= tgt;
      attn  <= 1'b1;
      ready <= 1'b1;
      if (recal_r) seek_inc <= 1'b0;
    end else if (ev_timeout) begin
      state    <= ST_FAIL;
      attn     <= 1'b1;
      ready    <= 1'b0;
      seek_inc <= 1'b1;
    end else if (moving) begin
      tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pend <= 1'b0;
    else if (ev_arrive || ev_timeout)  pend <= 1'b1;
    else if (ack)                      pend <= 1'b0;
  end

  p_move_lines_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    moving |-> (!attn && !ready));

  p_short_keeps_attn_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !start_recal && start_cyl == cyl && attn) |=> (attn && $stable(cyl) && !moving));

  p_arrive_sets_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arrive |=> (attn && ready && pend && !moving));

  p_timeout_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    moving |-> (tmo_cnt < TW'(TIMEOUT_CYC)));

  p_timeout_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (seek_inc && attn && !ready && state == ST_FAIL && $stable(cyl)));

  p_recal_home_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_arrive && recal_r) |=> (cyl == '0 && !seek_inc));

  p_stray_arrive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !moving && !start) |=> $stable(cyl));
endmodule

// File: rtl/sat_irq_merge.sv
module sat_irq_merge #(
  parameter int UNITS = 4
) (
  input  logic [UNITS-1:0] pend,
  input  logic [UNITS-1:0] seek_inc,
  input  logic             attn_mask,
  input  logic             err_mask,
  output logic             attn_irq,
  output logic             err_irq
);
  assign attn_irq = (|pend) && !attn_mask;
  assign err_irq  = (|seek_inc) && !err_mask;
endmodule

// File: rtl/seek_attn_tracker.sv
module seek_attn_tracker
  import sat_pkg::*;
#(
  parameter int UNITS       = 4,
  parameter int CYL_W       = 8,
  parameter int TIMEOUT_CYC = 5_000_000,
  parameter int HOLD_CYC    = 200,
  localparam int UNIT_W     = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic                   cmd_recal,
  input  logic [UNIT_W-1:0]      cmd_unit,
  input  logic [CYL_W-1:0]       cmd_cyl,
  input  logic [UNITS-1:0]       arrive,
  input  logic [UNITS-1:0]       attn_ack,
  input  logic                   attn_mask,
  input  logic                   err_mask,
  output logic [UNITS-1:0]       attn,
  output logic [UNITS-1:0]       ready,
  output logic [UNITS-1:0]       seek_inc,
  output logic [UNITS-1:0]       seeking,
  output logic [UNITS*CYL_W-1:0] unit_cyl,
  output logic                   hold_busy,
  output logic                   attn_irq,
  output logic                   err_irq
);
  logic             target_free;
  logic             accept;
  logic [UNITS-1:0] start_vec;
  logic [UNITS-1:0] pend;

  // Addressed unit exists and is not in motion.
  always_comb begin
    target_free = 1'b0;
    for (int u = 0; u < UNITS; u++)
      if (cmd_unit == UNIT_W'(u)) target_free = !seeking[u];
  end

  assign accept = cmd_valid && !hold_busy && target_free;

  sat_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(accept), .busy(hold_busy)
  );

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    assign start_vec[u] = accept && (cmd_unit == UNIT_W'(u));

    sat_unit #(.CYL_W(CYL_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_unit (
      .clk(clk), .rst_n(rst_n),
      .start(start_vec[u]), .start_recal(cmd_recal), .start_cyl(cmd_cyl),
      .arrive(arrive[u]), .ack(attn_ack[u]),
      .attn(attn[u]), .ready(ready[u]), .seek_inc(seek_inc[u]),
      .moving(seeking[u]), .pend(pend[u]),
      .cyl(unit_cyl[u*CYL_W +: CYL_W])
    );
  end

  sat_irq_merge #(.UNITS(UNITS)) u_irq (
    .pend(pend), .seek_inc(seek_inc),
    .attn_mask(attn_mask), .err_mask(err_mask),
    .attn_irq(attn_irq), .err_irq(err_irq)
  );

  p_accept_starts_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> hold_busy);

  p_one_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_vec));

  p_busy_unit_untouched_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(start_vec & seeking)) == 1'b0);
endmodule

// File: tb/seek_attn_tracker_test.sv
module seek_attn_tracker_test;
  localparam int  UNITS = 3;
  localparam int  CW    = 8;
  localparam int  TMO   = 40;
  localparam int  HOLD  = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_recal = 1'b0;
  logic [1:0] cmd_unit = '0;
  logic [CW-1:0] cmd_cyl = '0;
  logic [UNITS-1:0] arrive = '0, attn_ack = '0;
  logic attn_mask = 1'b0, err_mask = 1'b0;
  logic [UNITS-1:0] attn, ready, seek_inc, seeking;
  logic [UNITS*CW-1:0] unit_cyl;
  logic hold_busy, attn_irq, err_irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seek_attn_tracker #(.UNITS(UNITS), .CYL_W(CW), .TIMEOUT_CYC(TMO), .HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_recal(cmd_recal),
    .cmd_unit(cmd_unit), .cmd_cyl(cmd_cyl), .arrive(arrive), .attn_ack(attn_ack),
    .attn_mask(attn_mask), .err_mask(err_mask), .attn(attn), .ready(ready),
    .seek_inc(seek_inc), .seeking(seeking), .unit_cyl(unit_cyl),
    .hold_busy(hold_busy), .attn_irq(attn_irq), .err_irq(err_irq)
  );

  function automatic logic [CW-1:0] cyl_of(int u);
    return unit_cyl[u*CW +: CW];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic issue(int u, bit recal, int c);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_recal = recal; cmd_unit = 2'(u); cmd_cyl = CW'(c);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_arrive(int u);
    @(negedge clk); arrive[u] = 1'b1;
    @(negedge clk); arrive[u] = 1'b0;
  endtask

  task automatic pulse_ack(int u);
    @(negedge clk); attn_ack[u] = 1'b1;
    @(negedge clk); attn_ack[u] = 1'b0;
  endtask

  task automatic wait_hold();
    while (hold_busy) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int u = 0; u < UNITS; u++) begin
      check("R1", "attn", attn[u], 1);
      check("R1", "ready", ready[u], 1);
      check("R1", "seek_inc", seek_inc[u], 0);
      check("R1", "seeking", seeking[u], 0);
      check("R1", "cyl", cyl_of(u), 0);
    end
    check("R1", "hold_busy", hold_busy, 0);
    check("R1", "attn_irq", attn_irq, 0);
    check("R1", "err_irq", err_irq, 0);
  endtask

  task automatic t_seek_ok();
    issue(0, 1'b0, 25);
    check("R2", "seeking", seeking[0], 1);
    check("R2", "attn", attn[0], 0);
    check("R2", "ready", ready[0], 0);
    repeat (4) @(negedge clk);
    pulse_arrive(0);
    check("R4", "seeking", seeking[0], 0);
    check("R4", "attn", attn[0], 1);
    check("R4", "ready", ready[0], 1);
    check("R4", "cyl", cyl_of(0), 25);
    check("R4", "attn_irq", attn_irq, 1);
    pulse_ack(0);
    check("R10", "attn_irq after ack", attn_irq, 0);
  endtask

  task automatic t_shortcut();
    wait_hold();
    issue(0, 1'b0, 25);
    check("R3", "seeking", seeking[0], 0);
    check("R3", "attn", attn[0], 1);
    check("R3", "ready", ready[0], 1);
    check("R3", "cyl", cyl_of(0), 25);
    check("R3", "attn_irq", attn_irq, 0);
  endtask

  task automatic t_mask();
    wait_hold();
    attn_mask = 1'b1;
    issue(1, 1'b0, 9);
    pulse_arrive(1);
    check("R10", "masked attn_irq", attn_irq, 0);
    check("R4", "cyl unit1", cyl_of(1), 9);
    attn_mask = 1'b0;
    #1;
    check("R10", "unmasked attn_irq", attn_irq, 1);
    pulse_ack(1);
    check("R10", "attn_irq after ack", attn_irq, 0);
  endtask

  task automatic t_hold_overlap();
    wait_hold();
    issue(1, 1'b0, 50);
    check("R7", "hold_busy", hold_busy, 1);
    cmd_valid = 1'b1; cmd_recal = 1'b0; cmd_unit = 2'd2; cmd_cyl = 8'd7;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7", "unit2 ignored in hold", seeking[2], 0);
    wait_hold();
    issue(2, 1'b0, 7);
    check("R8", "unit2 moving", seeking[2], 1);
    check("R8", "unit1 moving", seeking[1], 1);
    wait_hold();
    issue(1, 1'b0, 99);
    check("R9", "no hold for busy unit", hold_busy, 0);
    pulse_arrive(2);
    check("R8", "unit2 cyl", cyl_of(2), 7);
    check("R8", "unit1 still moving", seeking[1], 1);
    pulse_arrive(1);
    check("R9", "unit1 keeps first target", cyl_of(1), 50);
    check("R8", "unit2 unchanged", cyl_of(2), 7);
    pulse_ack(1); pulse_ack(2);
  endtask

  task automatic t_timeout();
    wait_hold();
    issue(0, 1'b0, 3);
    repeat (TMO - 1) @(negedge clk);
    check("R5", "still moving at last cycle", seeking[0], 1);
    check("R5", "no seek_inc yet", seek_inc[0], 0);
    @(negedge clk);
    check("R5", "seek_inc", seek_inc[0], 1);
    check("R5", "attn", attn[0], 1);
    check("R5", "ready", ready[0], 0);
    check("R5", "cyl unchanged", cyl_of(0), 25);
    check("R5", "seeking", seeking[0], 0);
    check("R10", "err_irq", err_irq, 1);
    check("R5", "attn_irq", attn_irq, 1);
    err_mask = 1'b1;
    #1;
    check("R10", "masked err_irq", err_irq, 0);
    err_mask = 1'b0;
    pulse_arrive(0);
    check("R11", "stray arrive cyl", cyl_of(0), 25);
    check("R11", "stray arrive seek_inc", seek_inc[0], 1);
    check("R11", "stray arrive ready", ready[0], 0);
    pulse_ack(0);
  endtask

  task automatic t_recal();
    wait_hold();
    issue(0, 1'b1, 200);
    check("R6", "recal moving", seeking[0], 1);
    pulse_arrive(0);
    check("R6", "cyl zero", cyl_of(0), 0);
    check("R6", "seek_inc cleared", seek_inc[0], 0);
    check("R6", "attn", attn[0], 1);
    check("R6", "ready", ready[0], 1);
    check("R10", "err_irq clear", err_irq, 0);
    wait_hold();
    issue(0, 1'b1, 0);
    check("R6", "recal at zero still moves", seeking[0], 1);
    pulse_arrive(0);
    check("R6", "cyl zero again", cyl_of(0), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_seek_ok();
    t_shortcut();
    t_mask();
    t_hold_overlap();
    t_timeout();
    t_recal();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule